// File: doc/BRIEF.md
# Burst Bus Cycle Sequencer

This block runs one external access at a time on a 32-bit demultiplexed burst bus. A requester offers a word address, a direction and a length of one to four words, together with the wait-state settings of the memory region being addressed. The sequencer opens the access with a one-cycle address strobe. It inserts the programmed address-to-data and data-to-data waits, and then lets each data transfer complete. A transfer completes either at once or, when the region asks for it, under the control of an external ready input. After the final word it holds off for a recovery period before taking the next request.

A burst-terminate input can break a burst in two. The transfer in progress completes, and the sequencer starts a fresh address cycle for the words that remain. Regions that do not allow bursts get one address cycle per word. The transceiver controls (data enable and receive direction), the last-transfer flag and the internal-wait indicator are all derived from the sequencer state. A memory controller or transceiver can use them without extra glue logic.

Top module: `burst_bus_seq`

## Requirements
- R1: A request offered while `seq_idle` is 1 is taken at that clock edge. In the next cycle `addr_strb` is 1, and it stays high for that single cycle of each address cycle.
- R2: `bus_addr` carries word address bits [31:2]. After each completed transfer that is not the final one, bits [1:0] of `bus_addr` (byte address bits [3:2]) advance by one, wrapping from 3 to 0, and the upper bits stay unchanged.
- R3: After every address cycle, `cfg_first_wait` wait cycles (0 to 15) precede the first transfer. Between later words of the same address cycle, `cfg_next_wait` wait cycles (0 to 15) are inserted.
- R4: With `cfg_rdy_en` at 0, a transfer completes (`xfer_done` = 1) in the first cycle after the wait count is used up. With `cfg_rdy_en` at 1, `bus_ready` is looked at only from that cycle on, and the transfer is stretched for as long as both `bus_ready` and `bus_bterm` are 0.
- R5: With `cfg_rdy_en` at 1, a 1 on `bus_bterm` completes the current transfer regardless of `bus_ready`. If words remain, the next cycle is a new address cycle at the next address, and it is again followed by the first-access wait count.
- R6: `wait_ind` is 1 exactly in the cycles spent on the internal wait count. It is 0 in transfer cycles stretched by ready, in address cycles and in recovery.
- R7: `blast` is 1 in the transfer cycles of the final word of an address cycle once its wait count is used up. It stays 1 until that transfer completes, and it is 0 during waits.
- R8: `data_en` is 1 from the first wait or transfer cycle after an address cycle through the cycle in which that address cycle's last transfer completes. It is 0 during address, recovery and idle cycles.
- R9: `bus_write` (1 = write) takes the request's direction in the address cycle and holds it until the sequencer is idle again. `dir_rx` is its inverse (1 = receive) and never changes while `data_en` is 1.
- R10: After the final transfer, `cfg_recov_wait` recovery cycles (0 to 15) pass with `seq_idle`, `data_en`, `wait_ind` and `addr_strb` all at 0. `bus_ready` and `bus_bterm` cannot lengthen them. `seq_idle` returns to 1 in the following cycle.
- R11: With `cfg_burst_en` at 0, every word is its own access: each word gets an address cycle, the first-access wait count and `blast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_addr | input | 30 | Word address of first word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 2 | Words minus one |
| cfg_first_wait | input | 4 | Address-to-data wait count |
| cfg_next_wait | input | 4 | Data-to-data wait count |
| cfg_recov_wait | input | 4 | Recovery count after the final word |
| cfg_rdy_en | input | 1 | Use external ready and burst terminate |
| cfg_burst_en | input | 1 | Allow several words per address cycle |
| bus_ready | input | 1 | External ready |
| bus_bterm | input | 1 | Burst terminate |
| seq_idle | output | 1 | Sequencer free to take a request |
| addr_strb | output | 1 | Address strobe |
| bus_addr | output | 30 | Word address |
| bus_write | output | 1 | Access direction, 1 = write |
| wait_ind | output | 1 | Internal wait counter active |
| blast | output | 1 | Last transfer of the address cycle |
| data_en | output | 1 | Transceiver enable |
| dir_rx | output | 1 | Transceiver direction, 1 = receive |
| xfer_done | output | 1 | A data transfer completes this cycle |

## Verification
Every output is due one clock edge after the event that causes it. The strobe appears in the cycle after acceptance. Each wait, transfer and recovery cycle follows the previous one by one edge. `xfer_done` responds combinationally to `bus_ready` and `bus_bterm` within the same cycle. The bench therefore drives inputs on the falling edge, samples one nanosecond later, and walks a cycle-by-cycle expected trace, built from the configured counts, alongside the design. Random ready and terminate values are applied during waits, address cycles and recovery to show that they have no effect there.

// File: rtl/burst_bus_seq.sv
module burst_bus_seq #(
  parameter int AW = 30,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [1:0]    req_len,
  input  logic [CW-1:0] cfg_first_wait,
  input  logic [CW-1:0] cfg_next_wait,
  input  logic [CW-1:0] cfg_recov_wait,
  input  logic          cfg_rdy_en,
  input  logic          cfg_burst_en,
  input  logic          bus_ready,
  input  logic          bus_bterm,
  output logic          seq_idle,
  output logic          addr_strb,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic          wait_ind,
  output logic          blast,
  output logic          data_en,
  output logic          dir_rx,
  output logic          xfer_done
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_RECOV} st_t;

  st_t          st;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [1:0]    rem_q;
  logic [CW-1:0] wcnt;
  logic [CW-1:0] fw_q, nw_q, rw_q;
  logic          rdy_q, burst_q;

  logic counting, xfer_slot, bterm_hit, last_word;

  assign counting  = (st == S_DATA) && (wcnt != '0);
  assign xfer_slot = (st == S_DATA) && (wcnt == '0);
  assign bterm_hit = rdy_q && bus_bterm;
  assign last_word = (rem_q == 2'd0) || !burst_q;

  assign seq_idle  = (st == S_IDLE);
  assign addr_strb = (st == S_ADDR);
  assign bus_addr  = addr_q;
  assign bus_write = wr_q;
  assign dir_rx    = !wr_q;
  assign wait_ind  = counting;
  assign blast     = xfer_slot && last_word;
  assign data_en   = (st == S_DATA);
  assign xfer_done = xfer_slot && (!rdy_q || bus_ready || bterm_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      rem_q   <= 2'd0;
      wcnt    <= '0;
      fw_q    <= '0;
      nw_q    <= '0;
      rw_q    <= '0;
      rdy_q   <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wr_q    <= req_write;
          rem_q   <= req_len;
          fw_q    <= cfg_first_wait;
          nw_q    <= cfg_next_wait;
          rw_q    <= cfg_recov_wait;
          rdy_q   <= cfg_rdy_en;
          burst_q <= cfg_burst_en;
          st      <= S_ADDR;
        end
        S_ADDR: begin
          wcnt <= fw_q;
          st   <= S_DATA;
        end
        S_DATA: begin
          if (counting) begin
            wcnt <= wcnt - 1'b1;
          end else if (xfer_done) begin
            if (rem_q == 2'd0) begin
              wcnt <= rw_q;
              st   <= (rw_q == '0) ? S_IDLE : S_RECOV;
            end else begin
              addr_q[1:0] <= addr_q[1:0] + 2'd1;
              rem_q       <= rem_q - 2'd1;
              if (!burst_q || bterm_hit) st <= S_ADDR;
              else wcnt <= nw_q;
            end
          end
        end
        default: begin
          wcnt <= wcnt - 1'b1;
          if (wcnt == 1) st <= S_IDLE;
        end
      endcase
    end
  end

  a_r1_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strb |=> !addr_strb);

  a_r1_accept_to_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && req_valid) |=> addr_strb);

  a_r2_word_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !blast) |=> (bus_addr[1:0] == $past(bus_addr[1:0]) + 2'd1) &&
                              (bus_addr[AW-1:2] == $past(bus_addr[AW-1:2])));

  a_r4_ready_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && !wait_ind && !xfer_done) |=> data_en && !wait_ind && $stable(bus_addr));

  a_r6_wait_only_internal: assert property (@(posedge clk) disable iff (!rst_n)
    wait_ind |-> data_en && !xfer_done && !blast);

  a_r7_blast_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (blast && !xfer_done) |=> blast);

  a_r9_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |=> !data_en || $stable(dir_rx));

  a_r9_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_idle |=> seq_idle || $stable(bus_write));

  a_r10_recov_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_idle && !data_en && !addr_strb) |-> !wait_ind && !xfer_done);

endmodule

// File: tb/burst_bus_seq_tb_top.sv
module burst_bus_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [29:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_len = '0;
  logic [3:0]  cfg_first_wait = '0, cfg_next_wait = '0, cfg_recov_wait = '0;
  logic        cfg_rdy_en = 1'b0, cfg_burst_en = 1'b0;
  logic        bus_ready = 1'b0, bus_bterm = 1'b0;
  logic        seq_idle, addr_strb, bus_write, wait_ind, blast, data_en, dir_rx, xfer_done;
  logic [29:0] bus_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  burst_bus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_len(req_len), .cfg_first_wait(cfg_first_wait),
    .cfg_next_wait(cfg_next_wait), .cfg_recov_wait(cfg_recov_wait),
    .cfg_rdy_en(cfg_rdy_en), .cfg_burst_en(cfg_burst_en), .bus_ready(bus_ready),
    .bus_bterm(bus_bterm), .seq_idle(seq_idle), .addr_strb(addr_strb),
    .bus_addr(bus_addr), .bus_write(bus_write), .wait_ind(wait_ind), .blast(blast),
    .data_en(data_en), .dir_rx(dir_rx), .xfer_done(xfer_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic noise();
    bus_ready = 1'($urandom % 2);
    bus_bterm = 1'($urandom % 2);
  endtask

  task automatic run_req(input logic [29:0] a0, input logic [1:0] len, input logic wr,
                         input logic [3:0] fw, input logic [3:0] nw, input logic [3:0] rw,
                         input logic re, input logic be, input int rdy_pct);
    logic [29:0] a;
    int rem, w;
    bit fin, readdr, last, done, took_bt, r;
    req_addr = a0; req_len = len; req_write = wr;
    cfg_first_wait = fw; cfg_next_wait = nw; cfg_recov_wait = rw;
    cfg_rdy_en = re; cfg_burst_en = be;
    req_valid = 1'b1;
    #1 chk("R1 idle before request", seq_idle, 1);
    step();
    req_valid = 1'b0;
    a = a0; rem = len; fin = 0;
    while (!fin) begin
      noise();
      #1;
      chk("R1 strobe", addr_strb, 1);
      chk("R2 address in address cycle", bus_addr, a);
      chk("R8 den low in address cycle", data_en, 0);
      chk("R6 no wait in address cycle", wait_ind, 0);
      chk("R9 write dir", bus_write, wr);
      step();
      w = fw; readdr = 0;
      while (!readdr && !fin) begin
        for (int i = 0; i < w; i++) begin
          noise();
          #1;
          chk("R3 wait_ind during count", wait_ind, 1);
          chk("R8 den during wait", data_en, 1);
          chk("R1 strobe low in wait", addr_strb, 0);
          chk("R4 no transfer during count", xfer_done, 0);
          chk("R7 no blast during wait", blast, 0);
          chk("R9 dir_rx", dir_rx, !wr);
          step();
        end
        last = (rem == 0) || !be;
        done = 0; took_bt = 0;
        while (!done) begin
          r = (($urandom % 100) < rdy_pct);
          bus_ready = r;
          bus_bterm = (($urandom % 6) == 0);
          #1;
          done = !re || r || bus_bterm;
          took_bt = re && bus_bterm;
          chk("R6 wait low in transfer", wait_ind, 0);
          chk("R8 den in transfer", data_en, 1);
          chk("R7 blast", blast, last);
          chk("R4 R5 transfer completion", xfer_done, done);
          chk("R2 address in transfer", bus_addr, a);
          chk("R9 dir_rx stable", dir_rx, !wr);
          step();
        end
        if (rem == 0) fin = 1;
        else begin
          a[1:0] = a[1:0] + 2'd1;
          rem--;
          if (!be || took_bt) readdr = 1;  // R5 R11
          else w = nw;
        end
      end
    end
    for (int i = 0; i < rw; i++) begin
      noise();
      #1;
      chk("R10 recovery not idle", seq_idle, 0);
      chk("R10 recovery den low", data_en, 0);
      chk("R10 recovery no wait_ind", wait_ind, 0);
      chk("R10 recovery no strobe", addr_strb, 0);
      chk("R10 recovery no transfer", xfer_done, 0);
      chk("R9 write held in recovery", bus_write, wr);
      step();
    end
    bus_ready = 1'b0; bus_bterm = 1'b0;
    #1 chk("R10 idle after recovery", seq_idle, 1);
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%0d exp=<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    #1;
    chk("R1 reset idle", seq_idle, 1);
    chk("R1 reset strobe", addr_strb, 0);
    chk("R8 reset den", data_en, 0);
    chk("R6 reset wait", wait_ind, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_req(30'h0000_1000, 2'd0, 1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 100);
    run_req(30'h0000_2000, 2'd3, 1'b1, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 100);
    run_req(30'h1234_5673, 2'd3, 1'b0, 4'd2, 4'd1, 4'd3, 1'b0, 1'b1, 100);
    run_req(30'h0ABC_DEF2, 2'd3, 1'b1, 4'd15, 4'd15, 4'd15, 1'b1, 1'b1, 40);
    run_req(30'h0000_0041, 2'd3, 1'b0, 4'd1, 4'd0, 4'd2, 1'b0, 1'b0, 100);
    run_req(30'h3FFF_FFFF, 2'd2, 1'b1, 4'd3, 4'd2, 4'd1, 1'b1, 1'b0, 30);
    for (int k = 0; k < 300; k++) begin
      run_req(30'($urandom), 2'($urandom), 1'($urandom),
              4'($urandom), 4'($urandom), 4'($urandom),
              1'($urandom), 1'($urandom % 4 != 0), 30 + int'($urandom % 70));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule